// File: doc/BRIEF.md
# Multi-mode 16-bit counter/timer

This block is a 16-bit counter with one core that serves four modes. As a periodic timer it counts down on a divided time base. As an event counter it counts up or down on edges of an external input or on strobes from a neighbouring timer. As a one-shot it drives a single output pulse of programmable length. As a pulse measurer it captures the number of time-base ticks between two selected input edges. The time base and the input-filter sample rate both come from the block clock, which is nominally 48 MHz. Each is divided by a selectable power of two and delivered as a clock enable.

Software writes three words through a small write port: control, clock/event select and reload value. It reads the count through `count_q`. The external input is synchronised, optionally debounced, optionally inverted and edge-detected. An optional output pin toggles on wrap, or carries the one-shot pulse, with selectable polarity. A self-clearing reset bit clears the counter state without touching the configuration.

Top module: `cnt16_mtimer`

## Requirements
- R1: After `rst_n` is released, `count_q` reads 0 and `pin_out` is 0.
- R2: A write selects its target with `wr_sel`: 0 is the control word, 1 is the clock/event word and 2 is the reload value. A write with `wr_sel` = 3 is ignored, so the count cannot be written.
- R3: The control word has these fields: bit0 enable, bit1 self-reset, bits3:2 mode (0 timer, 1 event, 2 one-shot, 3 measure), bit4 input invert, bit5 direction, bit6 output enable, bit7 reload enable, bit8 filter bypass, bit9 power-down and bit10 output invert. In timer mode the counter decrements once per tick. With tick code k in clock/event bits3:0, a tick comes once every 2^k clocks, and codes above 7 behave as 7. After enabling, n clocks give floor(n/2^k) ticks.
- R4: Decrementing from 0 gives 0xFFFF and incrementing from 0xFFFF gives 0. When reload enable is set, the reload value is loaded instead.
- R5: In timer mode with direction = 1, a tick is skipped while the conditioned input level is low.
- R6: In event mode, clock/event bit10 selects the count source: 0 counts each clock with `nbr_ovf` high, 1 counts selected input edges. Direction 1 counts up and direction 0 counts down.
- R7: The edge select in clock/event bits9:8 picks 0 falling, 1 rising, 2 both, or 3 no input edge; code 3 means trigger on enable in one-shot mode.
- R8: Input invert flips the conditioned input level before gating and edge detection.
- R9: The input filter, with its sample-rate code in clock/event bits7:4, passes a new level only after 3 consecutive samples that differ from the current one. Filter bypass skips the filter.
- R10: In timer and event modes each wrap toggles the output state. `pin_out` is the output state XOR output invert when output enable is set, and 0 otherwise.
- R11: In one-shot mode a trigger loads the reload value and asserts the output. The counter then decrements per tick, and the tick taken at 0 deasserts the output and stops counting until the next trigger.
- R12: In measure mode the first selected edge clears the counter, which then counts ticks. Each later selected edge loads the elapsed tick count into the value read on `count_q`, then restarts the count.
- R13: Writing the self-reset bit clears the counter, the output state, the captured value and the mode state on the next clock, and the bit clears itself.
- R14: When enable is 0 or power-down is 1, all ticks and events stop and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 48 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 clock/event, 2 reload |
| wr_data | input | 16 | Write data |
| pin_in | input | 1 | External input, asynchronous |
| nbr_ovf | input | 1 | Overflow strobe from a neighbouring timer |
| count_q | output | 16 | Count, or the captured value in measure mode |
| pin_out | output | 1 | Output pin |

## Verification
A write lands on the clock edge that samples it, so a tick or event counts on the edge after that. Self-reset acts one edge after its write. A change on `pin_in` crosses two synchroniser flops and the edge register, so it is acted on at the third edge; with the filter in the path, three more filter samples are added. The bench drives inputs on falling edges and samples on the falling edge after the edge where each result is due. Where a pulse only has to settle, the bench allows a margin of several idle clocks before comparing.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;
   typedef enum logic [1:0] {
      MD_TIMER   = 2'd0,
      MD_EVENT   = 2'd1,
      MD_ONESHOT = 2'd2,
      MD_MEASURE = 2'd3
   } run_mode_e;

   typedef enum logic [1:0] {
      EG_FALL   = 2'd0,
      EG_RISE   = 2'd1,
      EG_BOTH   = 2'd2,
      EG_ENABLE = 2'd3
   } edge_sel_e;

   // control word, bit 10 down to bit 0
   typedef struct packed {
      logic      out_inv;
      logic      pdown;
      logic      bypass;
      logic      reload;
      logic      out_en;
      logic      dir;
      logic      in_inv;
      run_mode_e mode;
      logic      srst;
      logic      en;
   } ctrl_t;

   // clock/event word, bit 10 down to bit 0
   typedef struct packed {
      logic       evt_pin;
      edge_sel_e  edge_sel;
      logic [3:0] filt_sel;
      logic [3:0] tick_sel;
   } cev_t;

   localparam logic [1:0] SEL_CTRL   = 2'd0;
   localparam logic [1:0] SEL_CEV    = 2'd1;
   localparam logic [1:0] SEL_RELOAD = 2'd2;
endpackage

// File: rtl/cnt16_prescale.sv
module cnt16_prescale #(
   parameter int DIV_CODES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] tick_sel,
   input  logic [3:0] filt_sel,
   output logic       tick,
   output logic       ftick
);
   localparam int PRE_W = (DIV_CODES > 2) ? DIV_CODES - 1 : 1;
   localparam int IDX_W = (DIV_CODES > 1) ? $clog2(DIV_CODES) : 1;

   logic [PRE_W-1:0]     pre;
   logic [DIV_CODES-1:0] stb;
   logic [3:0]           t_idx, f_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre <= '0;
      else if (!run) pre <= '0;
      else           pre <= pre + 1'b1;
   end

   for (genvar k = 0; k < DIV_CODES; k++) begin : g_stb
      if (k == 0) begin : g_full
         assign stb[k] = run;
      end else begin : g_div
         assign stb[k] = run & (&pre[k-1:0]);
      end
   end

   always_comb begin
      t_idx = (int'(tick_sel) >= DIV_CODES) ? 4'(DIV_CODES - 1) : tick_sel;
      f_idx = (int'(filt_sel) >= DIV_CODES) ? 4'(DIV_CODES - 1) : filt_sel;
      tick  = stb[t_idx[IDX_W-1:0]];
      ftick = stb[f_idx[IDX_W-1:0]];
   end
endmodule

// File: rtl/cnt16_infilt.sv
module cnt16_infilt #(
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic ftick,
   input  logic bypass,
   input  logic inv,
   output logic level
);
   localparam int FC_W = (FILT_SAMPLES > 2) ? $clog2(FILT_SAMPLES) : 1;

   logic [SYNC_STAGES-1:0] sy;
   logic                   raw, held;
   logic [FC_W-1:0]        run_c;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sy <= '0;
         else        sy <= pin;
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sy <= '0;
         else        sy <= {sy[SYNC_STAGES-2:0], pin};
   end

   assign raw = sy[SYNC_STAGES-1];

   // new level accepted after FILT_SAMPLES differing samples in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= 1'b0;
         run_c <= '0;
      end else if (ftick) begin
         if (raw == held) begin
            run_c <= '0;
         end else if (run_c == FC_W'(FILT_SAMPLES - 1)) begin
            held  <= raw;
            run_c <= '0;
         end else begin
            run_c <= run_c + 1'b1;
         end
      end
   end

   assign level = (bypass ? raw : held) ^ inv;
endmodule

// File: rtl/cnt16_edgesel.sv
module cnt16_edgesel
   import cnt16_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level,
   input  logic [1:0] sel,
   output logic       hit
);
   logic prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;

   assign rise = level & ~prev;
   assign fall = ~level & prev;

   always_comb begin
      case (sel)
         EG_FALL: hit = fall;
         EG_RISE: hit = rise;
         EG_BOTH: hit = rise | fall;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cnt16_mtimer.sv
module cnt16_mtimer
   import cnt16_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int DIV_CODES    = 8,
   parameter int FILT_SAMPLES = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             pin_in,
   input  logic             nbr_ovf,
   output logic [CNT_W-1:0] count_q,
   output logic             pin_out
);
   localparam int CW_W = $bits(ctrl_t);
   localparam int EW_W = $bits(cev_t);

   if (CNT_W < CW_W || CNT_W < EW_W) begin : g_bad_width
      $error("CNT_W must hold the control and clock/event words");
   end
   if (DIV_CODES < 1 || DIV_CODES > 16) begin : g_bad_div
      $error("DIV_CODES must be 1 to 16");
   end
   if (FILT_SAMPLES < 2) begin : g_bad_filt
      $error("FILT_SAMPLES must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   ctrl_t            ctrl_q;
   cev_t             cev_q;
   logic [CNT_W-1:0] reload_q;
   logic             act, act_q, en_rise;
   logic             tick, ftick, level, hit;

   logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
   logic             out_q, out_d, os_run_q, os_run_d, meas_on_q, meas_on_d;
   logic             wrap, os_trig;
   logic [CNT_W:0]   stp;

   // ---------------- register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cev_q    <= '0;
         reload_q <= '0;
      end else begin
         if (ctrl_q.srst) ctrl_q.srst <= 1'b0;
         if (wr_en) begin
            case (wr_sel)
               SEL_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CW_W-1:0]);
               SEL_CEV:    cev_q    <= cev_t'(wr_data[EW_W-1:0]);
               SEL_RELOAD: reload_q <= wr_data;
               default:    ;
            endcase
         end
      end
   end

   assign act = ctrl_q.en & ~ctrl_q.pdown;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;

   assign en_rise = act & ~act_q;

   // ---------------- time base, input path, edges
   cnt16_prescale #(.DIV_CODES(DIV_CODES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(act),
      .tick_sel(cev_q.tick_sel), .filt_sel(cev_q.filt_sel),
      .tick(tick), .ftick(ftick)
   );

   cnt16_infilt #(.SYNC_STAGES(SYNC_STAGES), .FILT_SAMPLES(FILT_SAMPLES)) u_in (
      .clk(clk), .rst_n(rst_n), .pin(pin_in), .ftick(ftick),
      .bypass(ctrl_q.bypass), .inv(ctrl_q.in_inv), .level(level)
   );

   cnt16_edgesel u_edge (
      .clk(clk), .rst_n(rst_n), .level(level),
      .sel(cev_q.edge_sel), .hit(hit)
   );

   // ---------------- counter core
   function automatic logic [CNT_W:0] step_f(input logic [CNT_W-1:0] cur,
                                             input logic up, input logic rl,
                                             input logic [CNT_W-1:0] rv);
      logic [CNT_W-1:0] nx;
      logic             w;
      if (up) begin
         w  = &cur;
         nx = w ? (rl ? rv : {CNT_W{1'b0}}) : cur + 1'b1;
      end else begin
         w  = (cur == {CNT_W{1'b0}});
         nx = w ? (rl ? rv : {CNT_W{1'b1}}) : cur - 1'b1;
      end
      return {w, nx};
   endfunction

   always_comb begin
      cnt_d     = cnt_q;
      cap_d     = cap_q;
      out_d     = out_q;
      os_run_d  = os_run_q;
      meas_on_d = meas_on_q;
      wrap      = 1'b0;
      os_trig   = 1'b0;
      stp       = '0;
      if (ctrl_q.srst) begin
         cnt_d     = '0;
         cap_d     = '0;
         out_d     = 1'b0;
         os_run_d  = 1'b0;
         meas_on_d = 1'b0;
      end else if (act) begin
         case (ctrl_q.mode)
            MD_TIMER: begin
               if (tick && (!ctrl_q.dir || level)) begin
                  stp   = step_f(cnt_q, 1'b0, ctrl_q.reload, reload_q);
                  cnt_d = stp[CNT_W-1:0];
                  wrap  = stp[CNT_W];
               end
            end
            MD_EVENT: begin
               if (cev_q.evt_pin ? hit : nbr_ovf) begin
                  stp   = step_f(cnt_q, ctrl_q.dir, ctrl_q.reload, reload_q);
                  cnt_d = stp[CNT_W-1:0];
                  wrap  = stp[CNT_W];
               end
            end
            MD_ONESHOT: begin
               os_trig = !os_run_q &&
                         ((cev_q.edge_sel == EG_ENABLE) ? en_rise : hit);
               if (os_trig) begin
                  cnt_d    = reload_q;
                  out_d    = 1'b1;
                  os_run_d = 1'b1;
               end else if (os_run_q && tick) begin
                  if (cnt_q == '0) begin
                     out_d    = 1'b0;
                     os_run_d = 1'b0;
                  end else begin
                     cnt_d = cnt_q - 1'b1;
                  end
               end
            end
            MD_MEASURE: begin
               if (hit) begin
                  if (meas_on_q) cap_d = cnt_q + CNT_W'(tick);
                  cnt_d     = '0;
                  meas_on_d = 1'b1;
               end else if (meas_on_q && tick) begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         endcase
         if (wrap) out_d = ~out_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cap_q     <= '0;
         out_q     <= 1'b0;
         os_run_q  <= 1'b0;
         meas_on_q <= 1'b0;
      end else begin
         cnt_q     <= cnt_d;
         cap_q     <= cap_d;
         out_q     <= out_d;
         os_run_q  <= os_run_d;
         meas_on_q <= meas_on_d;
      end
   end

   assign count_q = (ctrl_q.mode == MD_MEASURE) ? cap_q : cnt_q;
   assign pin_out = ctrl_q.out_en & (out_q ^ ctrl_q.out_inv);
endmodule

// File: rtl/cnt16_mtimer_chk.sv
module cnt16_mtimer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srst,
   input logic             act,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] cnt,
   input logic             out_st,
   input logic             os_run,
   input logic             os_trig,
   input logic             wrap
);
   // R13: self-reset clears counter and output on the next clock
   p_srst_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (cnt == '0 && !out_st));

   // R14: inactive block holds its count and output
   p_freeze_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && !srst) |=> ($stable(cnt) && $stable(out_st)));

   // R3: timer mode moves by at most one step down away from zero
   p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && act && !srst && cnt != '0) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

   // R11: idle one-shot without a trigger keeps its count
   p_os_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !os_run && !os_trig && !srst) |=> $stable(cnt));

   // R10: a wrap in timer or event mode flips the output state
   p_wrap_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && mode[1] == 1'b0 && !srst) |=> (out_st != $past(out_st)));
endmodule

bind cnt16_mtimer cnt16_mtimer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .srst(ctrl_q.srst), .act(act),
   .mode(ctrl_q.mode), .cnt(cnt_q), .out_st(out_q), .os_run(os_run_q),
   .os_trig(os_trig), .wrap(wrap)
);

// File: tb/sim_cnt16_mtimer.sv
module sim_cnt16_mtimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        pin_in = 1'b0;
   logic        nbr_ovf = 1'b0;
   logic [15:0] count_q;
   logic        pin_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cnt16_mtimer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pin_in(pin_in), .nbr_ovf(nbr_ovf),
      .count_q(count_q), .pin_out(pin_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int hi, input int lo);
      pin_in = 1'b1; wt(hi);
      pin_in = 1'b0; wt(lo);
   endtask

   // {ctrl, clock/event, clocks after enable, expected count}, reload = 1000
   localparam logic [63:0] VT [0:10] = '{
      {16'h0081, 16'h0000, 16'd64,  16'd937},   // R3 R4 tick every clock
      {16'h0081, 16'h0002, 16'd64,  16'd985},   // R3 divide by 4
      {16'h0081, 16'h0005, 16'd64,  16'd999},   // R3 divide by 32
      {16'h0081, 16'h0006, 16'd64,  16'd1000},  // R3 divide by 64
      {16'h0081, 16'h0007, 16'd128, 16'd1000},  // R3 divide by 128
      {16'h0081, 16'h0009, 16'd128, 16'd1000},  // R3 code 9 acts as 7
      {16'h0001, 16'h0000, 16'd10,  16'hFFF6},  // R4 natural wrap
      {16'h00A1, 16'h0000, 16'd20,  16'd0},     // R5 gated, input low
      {16'h00B1, 16'h0000, 16'd20,  16'd981},   // R8 inverted input opens gate
      {16'h0281, 16'h0000, 16'd20,  16'd0},     // R14 power-down
      {16'h0080, 16'h0000, 16'd20,  16'd0}      // R14 enable clear
   };

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      wt(3);
      rst_n = 1'b1;
      wt(1);
      chk("R1 count after reset", count_q, 0);
      chk("R1 pin_out after reset", pin_out, 0);

      // R2: write to select 3 is ignored
      wr(2'd3, 16'h5555);
      wt(1);
      chk("R2 count not writable", count_q, 0);

      // table of timer configurations
      for (int i = 0; i < 11; i++) begin
         wr(2'd1, VT[i][47:32]);
         wr(2'd2, 16'd1000);
         wr(2'd0, VT[i][63:48]);
         wt(int'(VT[i][31:16]));
         if (count_q !== VT[i][15:0]) begin
            n_bad++;
            $display("FAIL row %0d (R3/R4/R5/R8/R14 table): actual=%0h expected=%0h",
                     i, count_q, VT[i][15:0]);
         end
         n_chk++;
         wr(2'd0, 16'h0002);
         wt(1);
      end

      // R6: neighbour overflow source, up then down
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0027);
      wt(1);
      nbr_ovf = 1'b1; wt(5); nbr_ovf = 1'b0; wt(1);
      chk("R6 neighbour strobes up", count_q, 5);
      wr(2'd0, 16'h0005);
      nbr_ovf = 1'b1; wt(2); nbr_ovf = 1'b0; wt(1);
      chk("R6 neighbour strobes down", count_q, 3);

      // R7: input edges, bypassed filter
      wr(2'd1, 16'h0500);
      wr(2'd0, 16'h0127);
      wt(2);
      pulse(4, 4); pulse(4, 4); pulse(4, 4); wt(6);
      chk("R7 rising edges", count_q, 3);
      wr(2'd1, 16'h0600);
      pulse(4, 4); pulse(4, 4); wt(6);
      chk("R7 both edges", count_q, 7);
      wr(2'd1, 16'h0400);
      pulse(4, 4); wt(6);
      chk("R7 falling edges", count_q, 8);
      wr(2'd1, 16'h0700);
      pulse(4, 4); wt(6);
      chk("R7 code 3 counts nothing", count_q, 8);

      // R9: filter rejects short pulse, passes long one
      wr(2'd1, 16'h0500);
      wr(2'd0, 16'h0027);
      wt(2);
      pulse(2, 8); wt(6);
      chk("R9 short glitch rejected", count_q, 0);
      pulse(5, 10); wt(6);
      chk("R9 stable pulse passed", count_q, 1);
      wr(2'd0, 16'h0125);
      pulse(2, 8); wt(6);
      chk("R9 bypass passes glitch", count_q, 2);

      // R10: output toggles on wrap, reload 3
      wr(2'd0, 16'h0002);
      wr(2'd2, 16'd3);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h00C1);
      wt(1);
      chk("R10 first wrap sets output", pin_out, 1);
      chk("R4 reload on wrap", count_q, 3);
      wt(4);
      chk("R10 second wrap clears output", pin_out, 0);
      wt(4);
      chk("R10 third wrap sets output", pin_out, 1);
      wr(2'd0, 16'h04C2);
      wt(1);
      chk("R10 inverted idle output high", pin_out, 1);
      wr(2'd0, 16'h0000);
      wt(1);
      chk("R10 disabled output low", pin_out, 0);

      // R11: one-shot triggered by enable
      wr(2'd2, 16'd4);
      wr(2'd1, 16'h0300);
      wr(2'd0, 16'h0049);
      wt(1);
      chk("R11 trigger loads reload", count_q, 4);
      chk("R11 trigger asserts output", pin_out, 1);
      wt(4);
      chk("R11 counted to zero", count_q, 0);
      chk("R11 output still high at zero", pin_out, 1);
      wt(1);
      chk("R11 expiry deasserts output", pin_out, 0);
      wt(4);
      chk("R11 stopped after expiry", count_q, 0);
      // R11: one-shot triggered by rising input edge
      wr(2'd1, 16'h0100);
      wr(2'd0, 16'h014B);
      wt(2);
      pin_in = 1'b1; wt(3);
      chk("R11 edge trigger loads reload", count_q, 4);
      chk("R11 edge trigger output", pin_out, 1);
      pin_in = 1'b0; wt(8);
      chk("R11 edge one-shot expired", pin_out, 0);

      // R12: measurement of periods 20 and 12
      wr(2'd0, 16'h0002);
      wr(2'd1, 16'h0100);
      wr(2'd0, 16'h010D);
      wt(2);
      pin_in = 1'b1; wt(5);
      chk("R12 nothing captured yet", count_q, 0);
      pin_in = 1'b0; wt(15);
      pin_in = 1'b1; wt(4);
      chk("R12 first period", count_q, 20);
      wt(2); pin_in = 1'b0; wt(6);
      pin_in = 1'b1; wt(4);
      chk("R12 second period", count_q, 12);
      pin_in = 1'b0;

      // R13: self-reset mid-run, bit clears itself
      wr(2'd0, 16'h0002);
      wr(2'd2, 16'd1000);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0081);
      wt(10);
      chk("R3 ten ticks", count_q, 991);
      wr(2'd0, 16'h0083);
      wt(1);
      chk("R13 self-reset clears count", count_q, 0);
      wt(1);
      chk("R13 counting resumes", count_q, 1000);

      // R14: freeze by enable and by power-down
      wt(5);
      wr(2'd0, 16'h0080);
      held = count_q;
      wt(10);
      chk("R14 disabled holds", count_q, held);
      wr(2'd0, 16'h0281);
      wt(10);
      chk("R14 power-down holds", count_q, held);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule